// File: doc/BRIEF.md
# Timed Fault Injection Controller

This block injects faults into several nets of a design under test while that design runs. One injection unit sits in series with each observed net. When no fault is active, the net passes through unchanged. A single configuration strobe loads four things for every unit: a fault choice for the first phase, a fault choice for the second phase, two phase lengths in clock cycles, and two flags. One flag picks whether the run starts at once or waits for an external trigger. The other flag asks for a reset pulse to the design under test.

After it accepts a configuration, the controller either starts phase 1 on the next cycle or waits for a rising edge on the trigger input. The trigger input passes through a synchroniser before the edge is detected. Phase 1 runs for its programmed length, and phase 2 follows straight after it. When phase 2 ends, the controller holds a done state, and every net passes through again until the next configuration. A status code shows where the sequence is. Because a phase length can reach about 1.3·10^8 cycles, one-second fault windows at 100 MHz are possible. A fault-free window can be set by choosing "none" for a phase.

Top module: `fault_inj_ctrl`

## Requirements
- R1: A unit's output equals its input combinationally whenever neither phase is active, and also whenever the fault code in effect is 0 (none), 6 or 7.
- R2: Fault code 1 forces the output to 0, and fault code 2 forces it to 1, for every cycle of the phase that selects it.
- R3: Fault code 3 (stuck-open) passes the input in the first cycle of the phase. In every later cycle of that phase, it holds the value the input had in that first cycle.
- R4: Fault code 4 (delay) outputs the value the input had one clock cycle earlier.
- R5: Fault code 5 (single-event upset) inverts the input in the first cycle of the phase only, and passes it unchanged for the rest of the phase.
- R6: The status output reads 0 for idle, 1 for waiting for trigger, 2 for phase 1, 3 for phase 2 and 4 for done. Phase 1 uses each unit's first fault field, and phase 2 uses each unit's second field. Each unit's fault field occupies bits [3i+2:3i] of the fault vector.
- R7: A phase lasts max(L,1) cycles, where L is its programmed length. Phase 2 starts in the cycle after phase 1 ends, and done follows in the cycle after phase 2 ends.
- R8: When the wait-for-trigger flag is 0, phase 1 is active in the cycle after the clock edge that accepts the configuration.
- R9: When the wait-for-trigger flag is 1, the controller stays in status 1 until the trigger input rises. Phase 1 becomes visible after the third clock edge that samples the trigger high. A trigger that is already high when waiting begins does not start the run.
- R10: A configuration strobe is accepted only in status 0 or 4. In any other state it changes neither the sequence nor the programmed lengths.
- R11: If the configuration carries the reset flag, the design-under-test reset output is high for DUT_RST_CYCLES cycles, starting in the cycle after acceptance. It is low otherwise.
- R12: After reset, the status reads 0, the design-under-test reset output is low, and all nets pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Configuration strobe |
| cfg_fault_a | input | 3*NUM_UNITS | Phase-1 fault code per unit |
| cfg_fault_b | input | 3*NUM_UNITS | Phase-2 fault code per unit |
| cfg_len_a | input | LEN_W | Phase-1 length in cycles |
| cfg_len_b | input | LEN_W | Phase-2 length in cycles |
| cfg_wait_trig | input | 1 | Wait for an external trigger edge before phase 1 |
| cfg_pulse_rst | input | 1 | Request a reset pulse to the design under test |
| trig_in | input | 1 | Asynchronous external trigger |
| net_in | input | NUM_UNITS | Nets from the design under test |
| net_out | output | NUM_UNITS | Nets after fault injection |
| dut_rst | output | 1 | Reset pulse to the design under test |
| status | output | 3 | Sequence state code |

## Verification
A phase counter that is wrong moves the status change to phase 2 or to done by a cycle or more. A length sweep that counts the cycles of each status value shows this at once. A fault register that is loaded wrongly, or a phase select that is swapped, shows up on net_out in the first cycle of the affected phase. The stuck-open and upset cases depend on the first-cycle marker. An error there shows up in the second cycle of the phase at the latest. A fault in the trigger path shows up as phase 1 starting one edge too early or too late, or as a run that starts on a trigger level that was already high.

// File: rtl/fij_pkg.sv
// Shared encodings for the fault injection controller.
// Assumes 3-bit fault codes; codes 6 and 7 behave as "no fault".
package fij_pkg;
    localparam int FLT_W = 3;

    localparam logic [FLT_W-1:0] FLT_NONE  = 3'd0;
    localparam logic [FLT_W-1:0] FLT_SA0   = 3'd1;
    localparam logic [FLT_W-1:0] FLT_SA1   = 3'd2;
    localparam logic [FLT_W-1:0] FLT_OPEN  = 3'd3;
    localparam logic [FLT_W-1:0] FLT_DELAY = 3'd4;
    localparam logic [FLT_W-1:0] FLT_SEU   = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_PH1  = 3'd2,
        ST_PH2  = 3'd3,
        ST_DONE = 3'd4
    } seq_state_e;
endpackage

// File: rtl/fij_trig_sync.sv
// Trigger synchroniser and rising-edge detector.
// Does: brings an asynchronous trigger through STAGES flops, then flags a
// one-cycle pulse on each low-to-high change of the synchronised level.
// Assumes: STAGES >= 2; trigger pulses last several clock cycles.
module fij_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic trig_rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the raw trigger through the synchroniser chain and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], trig_async};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Rising edge of the synchronised level.
    assign trig_rise = sync_q[STAGES-1] & ~last_q;

    // A detected edge never lasts two cycles.
    assert_single_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rise |=> !trig_rise);
endmodule

// File: rtl/fij_sequencer.sv
// Phase sequencer.
// Does: accepts a configuration in idle or done, optionally waits for a
// trigger edge, then times phase 1 and phase 2. It also drives the
// first-cycle marker and the reset pulse for the design under test.
// Assumes: lengths are counted in clock cycles; a length of 0 acts as 1.
module fij_sequencer
    import fij_pkg::*;
#(
    parameter int LEN_W          = 27,
    parameter int DUT_RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_wait_trig,
    input  logic             cfg_pulse_rst,
    input  logic [LEN_W-1:0] cfg_len_a,
    input  logic [LEN_W-1:0] cfg_len_b,
    input  logic             trig_rise,
    output logic             accept,
    output logic             ph_a,
    output logic             ph_b,
    output logic             ph_first,
    output logic             dut_rst,
    output logic [2:0]       status
);
    localparam int RST_W = $clog2(DUT_RST_CYCLES + 1);

    seq_state_e       state_q;
    logic [LEN_W-1:0] len_a_q;
    logic [LEN_W-1:0] len_b_q;
    logic [LEN_W-1:0] cnt_q;
    logic [RST_W-1:0] rst_cnt_q;

    // A configuration is taken only when no run is in progress.
    assign accept = cfg_load && (state_q == ST_IDLE || state_q == ST_DONE);

    // State and phase-cycle counter; the counter reads 1 in a phase's first cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            len_a_q <= '0;
            len_b_q <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        len_a_q <= cfg_len_a;
                        len_b_q <= cfg_len_b;
                        cnt_q   <= LEN_W'(1);
                        state_q <= cfg_wait_trig ? ST_WAIT : ST_PH1;
                    end
                end
                ST_WAIT: begin
                    if (trig_rise) begin
                        cnt_q   <= LEN_W'(1);
                        state_q <= ST_PH1;
                    end
                end
                ST_PH1: begin
                    if (cnt_q >= len_a_q) begin
                        cnt_q   <= LEN_W'(1);
                        state_q <= ST_PH2;
                    end else begin
                        cnt_q <= cnt_q + LEN_W'(1);
                    end
                end
                ST_PH2: begin
                    if (cnt_q >= len_b_q) begin
                        state_q <= ST_DONE;
                    end else begin
                        cnt_q <= cnt_q + LEN_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Reset-pulse length counter for the design under test.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_cnt_q <= '0;
        end else if (accept && cfg_pulse_rst) begin
            rst_cnt_q <= RST_W'(DUT_RST_CYCLES);
        end else if (rst_cnt_q != '0) begin
            rst_cnt_q <= rst_cnt_q - RST_W'(1);
        end
    end

    // Phase decode for the injection units.
    always_comb begin
        ph_a     = (state_q == ST_PH1);
        ph_b     = (state_q == ST_PH2);
        ph_first = (ph_a || ph_b) && (cnt_q == LEN_W'(1));
        dut_rst  = (rst_cnt_q != '0);
        status   = state_q;
    end

    // Phase 1 can only continue or hand over to phase 2.
    assert_ph1_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PH1) |=> (state_q == ST_PH1 || state_q == ST_PH2));
    // Phase 2 can only continue or finish.
    assert_ph2_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PH2) |=> (state_q == ST_PH2 || state_q == ST_DONE));
    // While phase 1 is short of its length, it stays and counts up by one.
    assert_len_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PH1 && cnt_q < len_a_q) |=>
            (state_q == ST_PH1 && cnt_q == $past(cnt_q) + LEN_W'(1)));
    // A strobe during a run leaves the programmed lengths alone.
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && (state_q == ST_PH1 || state_q == ST_PH2 || state_q == ST_WAIT)) |=>
            (len_a_q == $past(len_a_q) && len_b_q == $past(len_b_q)));
    // The reset pulse starts only after an accepted configuration that asks for it.
    assert_rst_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dut_rst) |-> $past(accept && cfg_pulse_rst));
endmodule

// File: rtl/fij_unit.sv
// Single fault injection unit in series with one net.
// Does: holds a fault code for each phase and applies the code of the
// active phase to the net; passes the net through otherwise.
// Assumes: ph_a and ph_b are never high together; ph_first marks the
// first cycle of a phase.
module fij_unit
    import fij_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [FLT_W-1:0] fault_a,
    input  logic [FLT_W-1:0] fault_b,
    input  logic             ph_a,
    input  logic             ph_b,
    input  logic             ph_first,
    input  logic             net_i,
    output logic             net_o
);
    logic [FLT_W-1:0] flt_a_q;
    logic [FLT_W-1:0] flt_b_q;
    logic [FLT_W-1:0] sel;
    logic             hold_q;
    logic             dly_q;
    logic             freeze;

    // Store this unit's fault pair when the sequencer accepts a configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_a_q <= FLT_NONE;
            flt_b_q <= FLT_NONE;
        end else if (load) begin
            flt_a_q <= fault_a;
            flt_b_q <= fault_b;
        end
    end

    // Fault code in effect this cycle.
    always_comb begin
        if (ph_a)      sel = flt_a_q;
        else if (ph_b) sel = flt_b_q;
        else           sel = FLT_NONE;
    end

    // Stuck-open freezes the tracking register after the phase's first cycle.
    assign freeze = (sel == FLT_OPEN) && !ph_first;

    // Track the net for stuck-open, and delay it by one stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            dly_q  <= 1'b0;
        end else begin
            if (!freeze) hold_q <= net_i;
            dly_q <= net_i;
        end
    end

    // Apply the selected fault model to the net.
    always_comb begin
        case (sel)
            FLT_SA0:   net_o = 1'b0;
            FLT_SA1:   net_o = 1'b1;
            FLT_OPEN:  net_o = ph_first ? net_i : hold_q;
            FLT_DELAY: net_o = dly_q;
            FLT_SEU:   net_o = ph_first ? ~net_i : net_i;
            default:   net_o = net_i;
        endcase
    end

    // After the first cycle, a stuck-open net does not move.
    assert_open_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == FLT_OPEN) && !ph_first) |-> (net_o == $past(net_o)));
    // A delayed net shows last cycle's input.
    assert_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == FLT_DELAY) |-> (net_o == $past(net_i)));
    // An upset flips the net in the first cycle.
    assert_seu_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == FLT_SEU) && ph_first) |-> (net_o != net_i));
    // Outside both phases the net passes through.
    assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ph_a && !ph_b) |-> (net_o == net_i));
endmodule

// File: rtl/fault_inj_ctrl.sv
// Timed fault injection controller (top).
// Does: ties the trigger synchroniser and the phase sequencer to one
// injection unit per net. Unit i reads fault bits [3i+2:3i].
// Assumes: trig_in is asynchronous; the nets are single-bit.
module fault_inj_ctrl
    import fij_pkg::*;
#(
    parameter int NUM_UNITS      = 3,
    parameter int LEN_W          = 27,
    parameter int DUT_RST_CYCLES = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_load,
    input  logic [FLT_W*NUM_UNITS-1:0] cfg_fault_a,
    input  logic [FLT_W*NUM_UNITS-1:0] cfg_fault_b,
    input  logic [LEN_W-1:0]           cfg_len_a,
    input  logic [LEN_W-1:0]           cfg_len_b,
    input  logic                       cfg_wait_trig,
    input  logic                       cfg_pulse_rst,
    input  logic                       trig_in,
    input  logic [NUM_UNITS-1:0]       net_in,
    output logic [NUM_UNITS-1:0]       net_out,
    output logic                       dut_rst,
    output logic [2:0]                 status
);
    logic trig_rise;
    logic accept;
    logic ph_a;
    logic ph_b;
    logic ph_first;

    fij_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_async (trig_in),
        .trig_rise  (trig_rise)
    );

    fij_sequencer #(.LEN_W(LEN_W), .DUT_RST_CYCLES(DUT_RST_CYCLES)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_load      (cfg_load),
        .cfg_wait_trig (cfg_wait_trig),
        .cfg_pulse_rst (cfg_pulse_rst),
        .cfg_len_a     (cfg_len_a),
        .cfg_len_b     (cfg_len_b),
        .trig_rise     (trig_rise),
        .accept        (accept),
        .ph_a          (ph_a),
        .ph_b          (ph_b),
        .ph_first      (ph_first),
        .dut_rst       (dut_rst),
        .status        (status)
    );

    for (genvar gi = 0; gi < NUM_UNITS; gi++) begin : g_unit
        fij_unit u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (accept),
            .fault_a  (cfg_fault_a[FLT_W*gi +: FLT_W]),
            .fault_b  (cfg_fault_b[FLT_W*gi +: FLT_W]),
            .ph_a     (ph_a),
            .ph_b     (ph_b),
            .ph_first (ph_first),
            .net_i    (net_in[gi]),
            .net_o    (net_out[gi])
        );
    end
endmodule

// File: tb/fault_inj_ctrl_bench.sv
module fault_inj_ctrl_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PERIOD = 10;
    localparam int NU         = 3;
    localparam int LW         = 27;
    localparam int RSTC       = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_load = 1'b0;
    logic [3*NU-1:0]   cfg_fault_a = '0;
    logic [3*NU-1:0]   cfg_fault_b = '0;
    logic [LW-1:0]     cfg_len_a = '0;
    logic [LW-1:0]     cfg_len_b = '0;
    logic              cfg_wait_trig = 1'b0;
    logic              cfg_pulse_rst = 1'b0;
    logic              trig_in = 1'b0;
    logic [NU-1:0]     net_in = '0;
    logic [NU-1:0]     net_out;
    logic              dut_rst;
    logic [2:0]        status;

    int   n_chk = 0;
    int   n_err = 0;
    bit   finished = 0;
    logic [7:0] lfsr = 8'hA5;
    logic [2:0] ua [NU];
    logic [2:0] ub [NU];
    logic [NU-1:0] prev_in;
    logic [NU-1:0] hold_v;

    fault_inj_ctrl #(.NUM_UNITS(NU), .LEN_W(LW), .DUT_RST_CYCLES(RSTC)) u_fault_inj_ctrl (
        .clk, .rst_n, .cfg_load, .cfg_fault_a, .cfg_fault_b, .cfg_len_a, .cfg_len_b,
        .cfg_wait_trig, .cfg_pulse_rst, .trig_in, .net_in, .net_out, .dut_rst, .status
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step_in();
        lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        net_in = lfsr[NU-1:0];
    endtask

    function automatic logic model(input logic [2:0] f, input logic iv, input logic pv,
                                   input logic hv, input logic first);
        case (f)
            3'd1:    return 1'b0;
            3'd2:    return 1'b1;
            3'd3:    return hv;
            3'd4:    return pv;
            3'd5:    return first ? ~iv : iv;
            default: return iv;
        endcase
    endfunction

    task automatic pack_cfg();
        for (int u = 0; u < NU; u++) begin
            cfg_fault_a[3*u +: 3] = ua[u];
            cfg_fault_b[3*u +: 3] = ub[u];
        end
    endtask

    // One negedge: new input, then sample.
    task automatic tick();
        @(negedge clk);
        step_in();
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int exp_st;
        repeat (3) @(negedge clk);
        // R12: reset state
        step_in(); #1;
        chk("R12 status in reset", status, 0);
        chk("R12 dut_rst in reset", dut_rst, 0);
        chk("R12 passthrough in reset", net_out, net_in);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R12 status after reset", status, 0);
        chk("R1 idle passthrough", net_out, net_in);

        // Sweep all fault pairs (R1..R8)
        exp_st = 0;
        for (int fa = 0; fa < 8; fa++) begin
            for (int fb = 0; fb < 8; fb++) begin
                int la, lb;
                ua[0] = 3'(fa); ua[1] = 3'((fa + 3) % 8); ua[2] = 3'(fb);
                ub[0] = 3'(fb); ub[1] = 3'((fb + 5) % 8); ub[2] = 3'(fa);
                la = 1 + fa % 3;
                lb = fb % 3;
                @(negedge clk);
                pack_cfg();
                cfg_len_a = LW'(la);
                cfg_len_b = LW'(lb);
                cfg_wait_trig = 1'b0;
                cfg_pulse_rst = 1'b0;
                cfg_load = 1'b1;
                step_in(); #1;
                chk("R6 status before run", status, exp_st);
                chk("R1 passthrough before run", net_out, net_in);
                prev_in = net_in;
                for (int p = 1; p <= 2; p++) begin
                    int n;
                    n = (p == 1) ? la : lb;
                    if (n < 1) n = 1;
                    for (int i = 1; i <= n; i++) begin
                        @(negedge clk);
                        cfg_load = 1'b0;
                        step_in(); #1;
                        chk((p == 1) ? "R8 R7 status phase1" : "R7 status phase2", status, p + 1);
                        if (p == 1 && i == 1) chk("R11 no pulse without flag", dut_rst, 0);
                        for (int u = 0; u < NU; u++) begin
                            logic [2:0] f;
                            f = (p == 1) ? ua[u] : ub[u];
                            if (i == 1) hold_v[u] = net_in[u];
                            chk("R1 R2 R3 R4 R5 R6 unit output", net_out[u],
                                model(f, net_in[u], prev_in[u], hold_v[u], i == 1));
                        end
                        prev_in = net_in;
                    end
                end
                tick();
                chk("R7 status done", status, 4);
                chk("R1 passthrough done", net_out, net_in);
                exp_st = 4;
            end
        end

        // R10 and R11: busy strobe ignored, reset pulse length
        @(negedge clk);
        for (int u = 0; u < NU; u++) begin ua[u] = 3'd0; ub[u] = 3'd0; end
        pack_cfg();
        cfg_len_a = LW'(6); cfg_len_b = LW'(6);
        cfg_pulse_rst = 1'b1; cfg_wait_trig = 1'b0; cfg_load = 1'b1;
        for (int c = 1; c <= 13; c++) begin
            @(negedge clk);
            cfg_load = 1'b0;
            if (c == 2 || c == 8) begin
                cfg_len_a = LW'(1); cfg_len_b = LW'(1); cfg_wait_trig = 1'b1;
                for (int u = 0; u < NU; u++) ua[u] = 3'd1;
                pack_cfg();
                cfg_load = 1'b1;
            end
            step_in(); #1;
            chk("R10 R7 status with busy strobe", status, (c <= 6) ? 2 : (c <= 12) ? 3 : 4);
            chk("R11 reset pulse window", dut_rst, (c <= RSTC) ? 1 : 0);
            chk("R10 faults unchanged by busy strobe", net_out, net_in);
        end

        // R9: wait for external trigger
        @(negedge clk);
        cfg_load = 1'b0;
        for (int u = 0; u < NU; u++) begin ua[u] = 3'd2; ub[u] = 3'd1; end
        pack_cfg();
        cfg_len_a = LW'(2); cfg_len_b = LW'(2);
        cfg_wait_trig = 1'b1; cfg_pulse_rst = 1'b0; cfg_load = 1'b1;
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk);
            cfg_load = 1'b0;
            step_in(); #1;
            chk("R9 waiting status", status, 1);
            chk("R9 R1 passthrough while waiting", net_out, net_in);
        end
        @(negedge clk);
        trig_in = 1'b1;
        tick(); chk("R9 after first trigger edge", status, 1);
        tick(); chk("R9 after second trigger edge", status, 1);
        tick(); chk("R9 phase1 after third edge", status, 2);
        chk("R9 R2 stuck-at-1 after trigger", net_out, {NU{1'b1}});
        tick(); chk("R9 phase1 second cycle", status, 2);
        tick(); chk("R9 phase2", status, 3);
        chk("R2 stuck-at-0 in phase2", net_out, 0);
        tick(); chk("R9 phase2 second cycle", status, 3);
        tick(); chk("R9 done", status, 4);

        // R9: trigger already high at arm does not start
        @(negedge clk);
        cfg_load = 1'b1;
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            cfg_load = 1'b0;
            step_in(); #1;
            chk("R9 high level does not start", status, 1);
        end
        @(negedge clk);
        trig_in = 1'b0;
        repeat (4) tick();
        chk("R9 falling trigger does not start", status, 1);
        @(negedge clk);
        trig_in = 1'b1;
        tick(); tick(); tick();
        chk("R9 restart on new edge", status, 2);
        repeat (4) tick();
        chk("R9 run completes", status, 4);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule